// File: doc/BRIEF.md
# Shared-Cache Idle Entry Sequencer

This block decides when a shared second-level memory subsystem may go into its own wait-for-interrupt idle state. The subsystem becomes eligible only when every core reports standby and the system has closed both of its external ports by asserting an inactivity input. The master bus has one such input and the coherent slave port has the other. The sequencer keeps a count of outstanding transactions on each port and drains them. It raises a subsystem standby output once both counts are zero. From that point the system may drop the main clock enable.

While the subsystem is idle, wake events fall into two classes. Releasing either inactivity input wakes only the shared subsystem, so that it can serve an external snoop or a slave-port transaction. An interrupt (IRQ or FIQ), a debug event or a soft reset wakes the cores as well, and the sequencer signals this with a one-cycle core wake pulse. After any wake the sequencer requests the clock enable and returns to normal operation once the enable is seen high. A wake that arrives during the drain cancels the entry attempt.

Top module: `shc_idle_seq`

## Requirements
- R1: A master request is accepted (mst_req_acc high, in the same cycle as mst_req_vld) only when the sequencer is in normal operation, mst_inact is low and the master outstanding count is below its maximum.
- R2: A slave-port request is accepted (slv_req_acc high, in the same cycle as slv_req_vld) only when the sequencer is in normal operation, slv_inact is low and the slave outstanding count is below its maximum.
- R3: Draining starts only if, at a clock edge, all core_stby bits are high, both inactivity inputs are high and no core-class wake input is high. If any of these conditions is missing, sub_stby stays low.
- R4: sub_stby rises at the clock edge after the edge at which both outstanding counts are zero during the drain. With counts already zero, this is the second edge after the entry conditions appear. sub_stby never rises while a count is nonzero.
- R5: No request is accepted on either port while the sequencer is draining or while sub_stby is high.
- R6: During the drain, any wake takes priority over a zero count and returns the sequencer to normal operation at the next edge, with core_wake staying low. A wake here is a core-class input, either inactivity input going low, or any core_stby bit going low.
- R7: While sub_stby is high, either inactivity input going low makes sub_stby fall at the next edge and raises wake_clk_req. core_wake stays low.
- R8: While sub_stby is high, a high level on irq, fiq, dbg_ev or soft_rst makes sub_stby fall at the next edge, and core_wake goes high for exactly that one cycle. This also holds when a subsystem-only wake arrives in the same cycle.
- R9: After a wake from standby, wake_clk_req stays high until clk_en is sampled high at a clock edge. It falls at that edge, and normal operation resumes.
- R10: Each port's count adds one on an accepted request and subtracts one on a response, and stays unchanged when both happen in the same cycle. The maximum is 2^CNT_W-1 (15 by default). A response while the count is zero is an error flagged by an assertion.
- R11: After reset the sequencer is in normal operation with sub_stby, core_wake and wake_clk_req low and both counts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (also the power-up reset) |
| core_stby | input | N_CORE | Per-core standby indications |
| mst_inact | input | 1 | System closes the master bus port |
| slv_inact | input | 1 | System closes the coherent slave port |
| mst_req_vld | input | 1 | New master request presented |
| mst_rsp | input | 1 | One master response returned |
| slv_req_vld | input | 1 | New slave-port request presented |
| slv_rsp | input | 1 | One slave-port response returned |
| irq | input | 1 | Interrupt request wake |
| fiq | input | 1 | Fast interrupt request wake |
| dbg_ev | input | 1 | Debug event wake |
| soft_rst | input | 1 | Soft reset wake |
| clk_en | input | 1 | Main clock enable as driven by the system |
| mst_req_acc | output | 1 | Master request accepted this cycle |
| slv_req_acc | output | 1 | Slave-port request accepted this cycle |
| sub_stby | output | 1 | Shared subsystem is idle |
| core_wake | output | 1 | One-cycle pulse: the wake also involves the cores |
| wake_clk_req | output | 1 | Request to raise the clock enable after a wake |

## Verification
Two functions can fall in the same cycle. During the drain, the last count reaching zero can coincide with a wake. In standby, a subsystem-only wake can coincide with a core-class wake. The bench provokes the first by raising irq, or by dropping one core standby bit, in the cycle where the drain would complete. It judges the result by sub_stby staying low at that edge and rising only two edges later. For the second, it releases an inactivity input in the same cycle as a debug event and expects the core_wake pulse to appear anyway. A response that lands in the same cycle as an accepted request at a full counter is judged by when acceptance is blocked again and how many responses the drain needs.

// File: rtl/shc_idle_pkg.sv
package shc_idle_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_STBY  = 2'd2,
    ST_WAKE  = 2'd3
  } seq_state_e;

  // wake class that also brings the cores out of standby
  function automatic logic core_class_wake(input logic irq, input logic fiq,
                                           input logic dbg, input logic srst);
    return irq | fiq | dbg | srst;
  endfunction

  // wake class that only needs the shared subsystem
  function automatic logic sub_class_wake(input logic m_inact, input logic s_inact);
    return !m_inact || !s_inact;
  endfunction

endpackage

// File: rtl/shc_out_cnt.sv
module shc_out_cnt #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_open,
  input  logic req_vld,
  input  logic rsp,
  output logic acc,
  output logic is_zero
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic             full;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic inc, input logic dec);
    logic [CNT_W-1:0] r;
    case ({inc, dec})
      2'b10:   r = cur + 1'b1;
      2'b01:   r = cur - 1'b1;
      default: r = cur;
    endcase
    return r;
  endfunction

  assign full    = (cnt == CMAX);
  assign is_zero = (cnt == '0);
  assign acc     = req_vld && gate_open && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= step(cnt, acc, rsp);
  end

  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp |-> !is_zero);

  // R10
  hold_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rsp) |=> full);

endmodule

// File: rtl/shc_idle_fsm.sv
module shc_idle_fsm
  import shc_idle_pkg::*;
#(
  parameter int N_CORE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CORE-1:0] core_stby,
  input  logic              m_inact,
  input  logic              s_inact,
  input  logic              core_ev,
  input  logic              cnt_zero,
  input  logic              clk_en,
  output seq_state_e        state,
  output logic              sub_stby,
  output logic              core_wake,
  output logic              wake_clk_req
);
  seq_state_e nxt;
  logic all_stby, sub_ev, entry_ok, drain_abort, core_wake_d;

  assign all_stby = &core_stby;
  assign sub_ev   = sub_class_wake(m_inact, s_inact);
  assign entry_ok = all_stby && !sub_ev && !core_ev;

  always_comb begin
    nxt         = state;
    drain_abort = 1'b0;
    core_wake_d = 1'b0;
    unique case (state)
      ST_RUN:   if (entry_ok) nxt = ST_DRAIN;
      ST_DRAIN: begin
        if (!entry_ok) begin
          nxt         = ST_RUN;
          drain_abort = 1'b1;
        end else if (cnt_zero) begin
          nxt = ST_STBY;
        end
      end
      ST_STBY: if (core_ev || sub_ev) begin
        nxt         = ST_WAKE;
        core_wake_d = core_ev;
      end
      ST_WAKE:  if (clk_en) nxt = ST_RUN;
      default:  nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      core_wake <= 1'b0;
    end else begin
      state     <= nxt;
      core_wake <= core_wake_d;
    end
  end

  assign sub_stby     = (state == ST_STBY);
  assign wake_clk_req = (state == ST_WAKE);

  // R4
  stby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_stby |-> cnt_zero);

  // R3
  stby_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sub_stby) |-> $past(all_stby && m_inact && s_inact));

  // R6
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_abort |=> (state == ST_RUN) && !core_wake);

  // R8
  core_wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_wake |=> !core_wake);

  // R8
  core_wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_wake |-> $past(sub_stby) && !sub_stby);

  // R9
  clk_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_clk_req && clk_en) |=> !wake_clk_req);

endmodule

// File: rtl/shc_idle_seq.sv
module shc_idle_seq
  import shc_idle_pkg::*;
#(
  parameter int N_CORE = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CORE-1:0] core_stby,
  input  logic              mst_inact,
  input  logic              slv_inact,
  input  logic              mst_req_vld,
  input  logic              mst_rsp,
  input  logic              slv_req_vld,
  input  logic              slv_rsp,
  input  logic              irq,
  input  logic              fiq,
  input  logic              dbg_ev,
  input  logic              soft_rst,
  input  logic              clk_en,
  output logic              mst_req_acc,
  output logic              slv_req_acc,
  output logic              sub_stby,
  output logic              core_wake,
  output logic              wake_clk_req
);
  localparam int N_PORT = 2;

  seq_state_e      state;
  logic [N_PORT-1:0] p_vld, p_rsp, p_inact, p_acc, p_zero;
  logic            core_ev, cnt_zero;

  assign p_vld   = {slv_req_vld, mst_req_vld};
  assign p_rsp   = {slv_rsp, mst_rsp};
  assign p_inact = {slv_inact, mst_inact};
  assign core_ev = core_class_wake(irq, fiq, dbg_ev, soft_rst);

  for (genvar g = 0; g < N_PORT; g++) begin : g_port
    shc_out_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate_open((state == ST_RUN) && !p_inact[g]),
      .req_vld  (p_vld[g]),
      .rsp      (p_rsp[g]),
      .acc      (p_acc[g]),
      .is_zero  (p_zero[g])
    );
  end

  assign cnt_zero    = &p_zero;
  assign mst_req_acc = p_acc[0];
  assign slv_req_acc = p_acc[1];

  shc_idle_fsm #(.N_CORE(N_CORE)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_stby   (core_stby),
    .m_inact     (mst_inact),
    .s_inact     (slv_inact),
    .core_ev     (core_ev),
    .cnt_zero    (cnt_zero),
    .clk_en      (clk_en),
    .state       (state),
    .sub_stby    (sub_stby),
    .core_wake   (core_wake),
    .wake_clk_req(wake_clk_req)
  );

  // R5
  no_accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_stby || state == ST_DRAIN) |-> (p_acc == '0));

  // R1
  mst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mst_inact |-> !mst_req_acc);

  // R2
  slv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slv_inact |-> !slv_req_acc);

endmodule

// File: tb/tb_shc_idle_seq.sv
`timescale 1ns/100ps
module tb_shc_idle_seq;
  localparam int N_CORE = 4;
  localparam int CNT_W  = 4;
  localparam int CMAXI  = (1 << CNT_W) - 1;
  localparam logic [N_CORE-1:0] ALL = {N_CORE{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_CORE-1:0] core_stby = '0;
  logic mst_inact = 0, slv_inact = 0, mst_req_vld = 0, mst_rsp = 0;
  logic slv_req_vld = 0, slv_rsp = 0, irq = 0, fiq = 0, dbg_ev = 0, soft_rst = 0;
  logic clk_en = 1'b1;
  logic mst_req_acc, slv_req_acc, sub_stby, core_wake, wake_clk_req;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  shc_idle_seq #(.N_CORE(N_CORE), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .core_stby(core_stby),
    .mst_inact(mst_inact), .slv_inact(slv_inact),
    .mst_req_vld(mst_req_vld), .mst_rsp(mst_rsp),
    .slv_req_vld(slv_req_vld), .slv_rsp(slv_rsp),
    .irq(irq), .fiq(fiq), .dbg_ev(dbg_ev), .soft_rst(soft_rst), .clk_en(clk_en),
    .mst_req_acc(mst_req_acc), .slv_req_acc(slv_req_acc),
    .sub_stby(sub_stby), .core_wake(core_wake), .wake_clk_req(wake_clk_req)
  );

  // {mst_vld, mst_inact, slv_vld, slv_inact, exp_mst_acc, exp_slv_acc}
  localparam logic [5:0] VEC [8] = '{
    6'b1010_11, 6'b1110_01, 6'b1011_10, 6'b1111_00,
    6'b0000_00, 6'b0110_01, 6'b1001_10, 6'b0011_00
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    core_stby = '0; mst_inact = 0; slv_inact = 0; mst_req_vld = 0; mst_rsp = 0;
    slv_req_vld = 0; slv_rsp = 0; irq = 0; fiq = 0; dbg_ev = 0; soft_rst = 0;
    clk_en = 1'b1;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic set_ev(input int k, input logic v);
    case (k)
      0: irq = v;
      1: fiq = v;
      2: dbg_ev = v;
      default: soft_rst = v;
    endcase
  endtask

  task automatic go_idle();
    core_stby = ALL; mst_inact = 1; slv_inact = 1;
    tick(); tick();
    check("R4 standby reached", sub_stby, 1'b1);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R11 reset state
    check("R11 sub_stby", sub_stby, 1'b0);
    check("R11 core_wake", core_wake, 1'b0);
    check("R11 wake_clk_req", wake_clk_req, 1'b0);

    // R1 R2 accept gating table
    for (int i = 0; i < 8; i++) begin
      tick();
      {mst_req_vld, mst_inact, slv_req_vld, slv_inact} = VEC[i][5:2];
      #1;
      check("R1 mst accept", mst_req_acc, VEC[i][1]);
      check("R2 slv accept", slv_req_acc, VEC[i][0]);
    end

    // R3 missing entry conditions
    do_reset();
    core_stby = ALL; mst_inact = 1;
    repeat (4) tick();
    check("R3 one port open", sub_stby, 1'b0);
    core_stby = ALL >> 1; slv_inact = 1;
    repeat (4) tick();
    check("R3 one core awake", sub_stby, 1'b0);
    core_stby = ALL; irq = 1;
    repeat (4) tick();
    check("R3 core wake pending", sub_stby, 1'b0);

    // R4 drain of outstanding work, R5 no accept
    do_reset();
    mst_req_vld = 1; slv_req_vld = 1;
    tick(); tick();
    slv_req_vld = 0;
    tick();
    mst_req_vld = 0;
    core_stby = ALL; mst_inact = 1; slv_inact = 1;
    repeat (3) tick();
    check("R4 held by counts", sub_stby, 1'b0);
    mst_req_vld = 1; slv_req_vld = 1; #1;
    check("R5 mst blocked drain", mst_req_acc, 1'b0);
    check("R5 slv blocked drain", slv_req_acc, 1'b0);
    mst_rsp = 1; slv_rsp = 1;
    tick(); tick();
    slv_rsp = 0;
    tick();
    mst_rsp = 0;
    check("R4 low at zero edge", sub_stby, 1'b0);
    tick();
    check("R4 rises after zero", sub_stby, 1'b1);
    check("R5 mst blocked stby", mst_req_acc, 1'b0);
    mst_req_vld = 0; slv_req_vld = 0;

    // R7 subsystem-only wake, R9 clock request
    slv_inact = 0;
    tick();
    check("R7 sub_stby falls", sub_stby, 1'b0);
    check("R7 no core wake", core_wake, 1'b0);
    check("R9 clk req raised", wake_clk_req, 1'b1);
    clk_en = 0;
    tick(); tick();
    check("R9 clk req held", wake_clk_req, 1'b1);
    clk_en = 1;
    tick();
    check("R9 clk req drops", wake_clk_req, 1'b0);
    mst_inact = 0; mst_req_vld = 1; #1;
    check("R9 back to run", mst_req_acc, 1'b1);
    mst_req_vld = 0;

    // R8 each core-class wake
    for (int k = 0; k < 4; k++) begin
      do_reset();
      go_idle();
      set_ev(k, 1'b1);
      tick();
      set_ev(k, 1'b0);
      check("R8 core_wake pulse", core_wake, 1'b1);
      check("R8 sub_stby falls", sub_stby, 1'b0);
      tick();
      check("R8 pulse one cycle", core_wake, 1'b0);
    end

    // R8 both classes in one cycle
    do_reset();
    go_idle();
    dbg_ev = 1; mst_inact = 0;
    tick();
    dbg_ev = 0;
    check("R8 both classes", core_wake, 1'b1);

    // R6 abort by interrupt as drain completes
    do_reset();
    core_stby = ALL; mst_inact = 1; slv_inact = 1;
    tick();
    irq = 1;
    tick();
    irq = 0;
    check("R6 abort irq", sub_stby, 1'b0);
    check("R6 no core wake", core_wake, 1'b0);
    tick();
    check("R6 redrain", sub_stby, 1'b0);
    tick();
    check("R6 late entry", sub_stby, 1'b1);

    // R6 abort by core leaving standby
    do_reset();
    core_stby = ALL; mst_inact = 1; slv_inact = 1;
    tick();
    core_stby = ALL >> 1;
    tick();
    core_stby = ALL;
    check("R6 abort core", sub_stby, 1'b0);
    tick(); tick();
    check("R6 core late entry", sub_stby, 1'b1);

    // R10 saturation and simultaneous step
    do_reset();
    mst_req_vld = 1;
    for (int i = 0; i < CMAXI; i++) tick();
    #1;
    check("R10 full blocks", mst_req_acc, 1'b0);
    mst_rsp = 1;
    tick(); #1;
    check("R10 after response", mst_req_acc, 1'b1);
    tick();
    mst_rsp = 0; #1;
    check("R10 accept+resp hold", mst_req_acc, 1'b1);
    tick(); #1;
    check("R10 full again", mst_req_acc, 1'b0);
    mst_req_vld = 0;
    core_stby = ALL; mst_inact = 1; slv_inact = 1; mst_rsp = 1;
    for (int i = 0; i < CMAXI; i++) tick();
    mst_rsp = 0;
    check("R10 drain count", sub_stby, 1'b0);
    tick();
    check("R10 drained", sub_stby, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule